// File: doc/BRIEF.md
# PHY Interrupt Source and Basic Register Block

This block sits inside an Ethernet PHY's register file, which software reaches through indexed reads and writes. It turns changes on the PHY's link state into latched event bits in an 8-bit interrupt source register. An 8-bit mask register selects which of those bits raise a single summary interrupt line, and that line goes to the MAC-side interrupt aggregator. The block also holds the basic control, basic status and auto-negotiation advertise registers. The status register's link bits follow the link state.

Software normally enables the events it cares about in the mask register. When the summary line rises, it reads the source register. That read returns the pending events and clears all of them in the same access. Right after reset the block samples the link once, so the first event reflects the current link state. The serial management framing and the real auto-negotiation are handled elsewhere.

Top module: `phy_intr_regfile`

## Requirements
- R1: After reset, register 0 (control) reads 0x3000, register 4 (advertise) reads 0x01E1 and register 30 (mask) reads 0. Register 1 (status) reads 0x7809 when the link is down and 0x782D when it is up.
- R2: When the link goes up, source bits 0x80 (energy detected) and 0x40 (auto-negotiation complete) are set, and status bits 0x0024 are set.
- R3: When the link goes down, source bit 0x10 (link down) is set and status bits 0x0024 are cleared.
- R4: A read of register 29 returns the source bits latched before that access, then clears them all.
- R5: If a link event occurs in the same cycle as a read of register 29, the new event bits remain set after the clear, and a later read returns them.
- R6: A write to register 30 keeps only data bits 7..0, and register 30 reads back that value.
- R7: `phy_irq_o` is high exactly when (source AND mask) is nonzero. It follows every change to the source or the mask.
- R8: A write to register 4 stores (data AND 0x2D7F) OR 0x0080. A write to register 0 stores the full 16-bit value.
- R9: Register 6 reads as 1. Unimplemented indices read as 0 and ignore writes. Writes to registers 1, 6 and 29 have no effect.
- R10: In the first cycle after reset, the block evaluates the link input as an event. A down link latches 0x10 and an up link latches 0xC0.
- R11: Read data appears on `acc_rdata_o` one clock after the access is accepted. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up_i | input | 1 | Current link state, 1 = up |
| acc_en_i | input | 1 | Register access strobe, one access per cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_idx_i | input | 5 | Register index |
| acc_wdata_i | input | 16 | Write data |
| acc_rdata_o | output | 16 | Registered read data |
| phy_irq_o | output | 1 | Summary interrupt to the MAC aggregator |

## Verification
The assertions watch cycle-level invariants on every clock. Status link bits must track the direction of each event. A read of the source with no coincident event must leave it empty. Coincident event bits must survive a clear. Mask writes must keep their low byte, advertise writes must be filtered, and an event must be evaluated in the first cycle after reset. Only the bench's scenarios can show the values software actually sees through the index decode. Those include read-to-clear ordering across consecutive reads, the summary line reacting to mask changes, and ignored writes to read-only and unimplemented indices.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
    localparam int REG_W = 16;
    localparam int IDX_W = 5;
    localparam int SRC_W = 8;

    localparam logic [IDX_W-1:0] IDX_CTRL = 5'd0;
    localparam logic [IDX_W-1:0] IDX_STAT = 5'd1;
    localparam logic [IDX_W-1:0] IDX_ADV  = 5'd4;
    localparam logic [IDX_W-1:0] IDX_ANX  = 5'd6;
    localparam logic [IDX_W-1:0] IDX_ISRC = 5'd29;
    localparam logic [IDX_W-1:0] IDX_IMSK = 5'd30;

    localparam logic [REG_W-1:0] CTRL_RST  = 16'h3000;
    localparam logic [REG_W-1:0] STAT_BASE = 16'h7809;
    localparam logic [REG_W-1:0] STAT_LINK = 16'h0024;
    localparam logic [REG_W-1:0] ADV_RST   = 16'h01E1;
    localparam logic [REG_W-1:0] ADV_KEEP  = 16'h2D7F;
    localparam logic [REG_W-1:0] ADV_FORCE = 16'h0080;
    localparam logic [REG_W-1:0] ANX_VAL   = 16'h0001;

    localparam logic [SRC_W-1:0] EV_ENERGY    = 8'h80;
    localparam logic [SRC_W-1:0] EV_ANEG_DONE = 8'h40;
    localparam logic [SRC_W-1:0] EV_RFAULT    = 8'h20;
    localparam logic [SRC_W-1:0] EV_DOWN      = 8'h10;
    localparam logic [SRC_W-1:0] EV_LP_ACK    = 8'h08;
    localparam logic [SRC_W-1:0] EV_PDFAULT   = 8'h04;
    localparam logic [SRC_W-1:0] EV_PAGE      = 8'h02;

    typedef struct packed {
        logic fire;
        logic up;
    } link_evt_t;

    typedef struct packed {
        logic             en;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] wdata;
    } acc_req_t;

    function automatic logic [SRC_W-1:0] evt_bits(link_evt_t e);
        if (!e.fire) return '0;
        return e.up ? (EV_ENERGY | EV_ANEG_DONE) : EV_DOWN;
    endfunction

    function automatic logic [REG_W-1:0] adv_filter(logic [REG_W-1:0] v);
        return (v & ADV_KEEP) | ADV_FORCE;
    endfunction
endpackage

// File: rtl/phy_link_tracker.sv
module phy_link_tracker
    import phy_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      link_i,
    output link_evt_t evt_o,
    output logic      link_ok_o
);
    logic pending_q;
    logic link_q;

    always_comb begin
        evt_o.fire = pending_q | (link_i != link_q);
        evt_o.up   = link_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b1;
            link_q    <= 1'b0;
            link_ok_o <= 1'b0;
        end else begin
            pending_q <= 1'b0;
            link_q    <= link_i;
            if (evt_o.fire) link_ok_o <= evt_o.up;
        end
    end

    // R2
    up_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_o.fire && evt_o.up) |=> link_ok_o);
    // R3
    down_clears_status_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_o.fire && !evt_o.up) |=> !link_ok_o);
    // R10
    post_reset_eval_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> evt_o.fire);
endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
    import phy_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  link_evt_t        evt_i,
    input  logic             rd_src_i,
    input  logic             wr_mask_i,
    input  logic [SRC_W-1:0] mask_wdata_i,
    output logic [SRC_W-1:0] src_o,
    output logic [SRC_W-1:0] mask_o,
    output logic             irq_o
);
    logic [SRC_W-1:0] new_bits;

    assign new_bits = evt_bits(evt_i);
    assign irq_o    = |(src_o & mask_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_o  <= '0;
            mask_o <= '0;
        end else begin
            src_o <= (rd_src_i ? '0 : src_o) | new_bits;
            if (wr_mask_i) mask_o <= mask_wdata_i;
        end
    end

    // R4
    read_clears_src_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_src_i && !evt_i.fire) |=> (src_o == '0 && !irq_o));
    // R5
    event_survives_clear_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.fire |=> ((src_o & $past(new_bits)) == $past(new_bits)));
    // R6
    mask_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_mask_i |=> (mask_o == $past(mask_wdata_i)));
endmodule

// File: rtl/phy_intr_regfile.sv
module phy_intr_regfile
    import phy_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             link_up_i,
    input  logic             acc_en_i,
    input  logic             acc_wr_i,
    input  logic [IDX_W-1:0] acc_idx_i,
    input  logic [REG_W-1:0] acc_wdata_i,
    output logic [REG_W-1:0] acc_rdata_o,
    output logic             phy_irq_o
);
    acc_req_t         req;
    link_evt_t        evt;
    logic             link_ok;
    logic [SRC_W-1:0] src, mask;
    logic [REG_W-1:0] ctrl_q, adv_q, rd_val;
    logic             rd_strobe, wr_strobe;

    assign req       = '{en: acc_en_i, wr: acc_wr_i, idx: acc_idx_i, wdata: acc_wdata_i};
    assign rd_strobe = req.en && !req.wr;
    assign wr_strobe = req.en && req.wr;

    phy_link_tracker u_link (
        .clk       (clk),
        .rst       (rst),
        .link_i    (link_up_i),
        .evt_o     (evt),
        .link_ok_o (link_ok)
    );

    phy_irq_regs u_irq (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .rd_src_i     (rd_strobe && req.idx == IDX_ISRC),
        .wr_mask_i    (wr_strobe && req.idx == IDX_IMSK),
        .mask_wdata_i (req.wdata[SRC_W-1:0]),
        .src_o        (src),
        .mask_o       (mask),
        .irq_o        (phy_irq_o)
    );

    always_comb begin
        unique case (req.idx)
            IDX_CTRL: rd_val = ctrl_q;
            IDX_STAT: rd_val = STAT_BASE | (link_ok ? STAT_LINK : '0);
            IDX_ADV:  rd_val = adv_q;
            IDX_ANX:  rd_val = ANX_VAL;
            IDX_ISRC: rd_val = {{(REG_W-SRC_W){1'b0}}, src};
            IDX_IMSK: rd_val = {{(REG_W-SRC_W){1'b0}}, mask};
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= CTRL_RST;
            adv_q       <= ADV_RST;
            acc_rdata_o <= '0;
        end else begin
            if (rd_strobe) acc_rdata_o <= rd_val;
            if (wr_strobe && req.idx == IDX_CTRL) ctrl_q <= req.wdata;
            if (wr_strobe && req.idx == IDX_ADV)  adv_q  <= adv_filter(req.wdata);
        end
    end

    // R8
    adv_filter_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && req.idx == IDX_ADV) |=>
            (adv_q == (($past(acc_wdata_i) & 16'h2D7F) | 16'h0080)));
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(acc_rdata_o));
endmodule

// File: tb/phy_intr_regfile_tb.sv
module phy_intr_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up_i = 1'b0;
    logic        acc_en_i = 1'b0, acc_wr_i = 1'b0;
    logic [4:0]  acc_idx_i = '0;
    logic [15:0] acc_wdata_i = '0;
    logic [15:0] acc_rdata_o;
    logic        phy_irq_o;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    phy_intr_regfile dut_i (.*);

    // wr, idx, wdata, expected readback of idx, requirement number
    typedef struct packed {
        logic        wr;
        logic [4:0]  idx;
        logic [15:0] wdata;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd30, 16'h01FF, 16'h00FF, 8'd6},  // R6 low byte kept
        '{1'b1, 5'd4,  16'hFFFF, 16'h2DFF, 8'd8},  // R8 filter
        '{1'b1, 5'd4,  16'h0000, 16'h0080, 8'd8},  // R8 forced bit
        '{1'b1, 5'd0,  16'h1100, 16'h1100, 8'd8},  // R8 control full store
        '{1'b0, 5'd6,  16'h0000, 16'h0001, 8'd9},  // R9 expansion
        '{1'b1, 5'd6,  16'h5555, 16'h0001, 8'd9},  // R9 write ignored
        '{1'b1, 5'd1,  16'h0000, 16'h7809, 8'd9},  // R9 status read-only
        '{1'b1, 5'd12, 16'h1234, 16'h0000, 8'd9},  // R9 unimplemented
        '{1'b1, 5'd29, 16'h00FF, 16'h0000, 8'd9},  // R9 source not writable
        '{1'b0, 5'd31, 16'h0000, 16'h0000, 8'd9}   // R9 unimplemented read
    };

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [4:0] idx, input logic [15:0] d);
        @(negedge clk);
        acc_en_i = 1'b1; acc_wr_i = wr; acc_idx_i = idx; acc_wdata_i = d;
        @(negedge clk);
        acc_en_i = 1'b0; acc_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] idx, output logic [15:0] v);
        access(1'b0, idx, 16'h0);
        v = acc_rdata_o;
    endtask

    task automatic set_link(input logic up);
        @(negedge clk);
        link_up_i = up;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic up);
        @(negedge clk);
        rst = 1'b1; link_up_i = up;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v, held;
        do_reset(1'b0);
        rd(5'd0, v);  check("R1 control", v, 16'h3000);
        rd(5'd4, v);  check("R1 advertise", v, 16'h01E1);
        rd(5'd30, v); check("R1 mask", v, 16'h0000);
        rd(5'd1, v);  check("R1 status down", v, 16'h7809);
        check("R7 irq masked", {15'h0, phy_irq_o}, 16'h0);
        rd(5'd29, v); check("R10 down latched", v, 16'h0010);
        rd(5'd29, v); check("R4 cleared", v, 16'h0000);

        foreach (VECS[i]) begin
            if (VECS[i].wr) access(1'b1, VECS[i].idx, VECS[i].wdata);
            rd(VECS[i].idx, v);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
        end

        // R11: a write does not disturb the last read data
        held = acc_rdata_o;
        access(1'b1, 5'd0, 16'h3000);
        check("R11 hold", acc_rdata_o, held);

        // mask = 0xFF from the table; R2 and R7
        set_link(1'b1);
        check("R7 irq on up", {15'h0, phy_irq_o}, 16'h1);
        rd(5'd1, v);  check("R2 status up", v, 16'h782D);
        rd(5'd29, v); check("R2 up bits", v, 16'h00C0);
        check("R4 irq after clear", {15'h0, phy_irq_o}, 16'h0);

        // R3 with mask selecting only link down
        access(1'b1, 5'd30, 16'h0010);
        set_link(1'b0);
        check("R7 irq on down", {15'h0, phy_irq_o}, 16'h1);
        rd(5'd1, v); check("R3 status down", v, 16'h7809);
        access(1'b1, 5'd30, 16'h0080);
        check("R7 irq after mask change", {15'h0, phy_irq_o}, 16'h0);

        // R5: link up coincides with read of source
        @(negedge clk);
        link_up_i = 1'b1;
        acc_en_i = 1'b1; acc_wr_i = 1'b0; acc_idx_i = 5'd29;
        @(negedge clk);
        acc_en_i = 1'b0;
        check("R4 old bits returned", acc_rdata_o, 16'h0010);
        check("R7 irq new energy bit", {15'h0, phy_irq_o}, 16'h1);
        rd(5'd29, v); check("R5 new bits kept", v, 16'h00C0);

        // R10 / R1: reset while link is up
        do_reset(1'b1);
        rd(5'd1, v);  check("R1 status up after reset", v, 16'h782D);
        rd(5'd30, v); check("R1 mask after reset", v, 16'h0000);
        rd(5'd29, v); check("R10 up latched", v, 16'h00C0);

        finish_run();
    end
endmodule